// File: doc/BRIEF.md
# Interrupt Descriptor Queue Manager

This block gathers interrupt descriptors raised by event sources and delivers them to a circular ring that the host keeps in shared memory. Each event carries a class number and a descriptor word. Events whose class is masked are discarded. The rest wait in an internal FIFO. A drain engine moves them one at a time through a valid/ready bus-master write port. Each descriptor goes to the ring slot that follows the last one written. When the ring has no free slot, the engine stops. It starts again once the host publishes a new read index.

Firmware programs the ring base address, the ring length in words, the host read index and the class mask through a small register port. A status word reports the next ring slot to be written, whether the ring is full, how many descriptors have landed since the status was last read, and a sticky overflow flag. Reading the status word clears the count. A level interrupt stays high while that count is nonzero.

Several actions return the queue state to its initial condition while the block keeps running: reprogramming the base or the length, a soft or global init command, or a reload read. These actions also discard everything still buffered or in flight.

Top module: `irq_dq_mgr`

## Requirements
- R1: After reset the status word reads zero, and both `irq_o` and `mw_valid` are low.
- R2: Mask register (address 3) bit i set discards events of class i. Every other event produces exactly one memory write, and writes come out in arrival order.
- R3: Write address = base (address 0, bits 31:2 kept, bits 1:0 forced to zero) + 4 × ring index. The index wraps to 0 after length−1.
- R4: A length written at address 1 is clamped to the range 2..LEN_MAX (default 32768). Reading address 1 returns the clamped value.
- R5: The ring is full when the index after the current one equals the host read index (address 2). While it is full, no write request is raised and status bit 15 is set. Draining resumes after the host writes a new read index, and events keep entering the FIFO meanwhile.
- R6: The FIFO holds FIFO_DEPTH descriptors. An unmasked event that arrives while the FIFO is full is dropped and sets the sticky status bit 31.
- R7: Status (address 4) reads as {overflow[31], count[30:16], full[15], index[14:0]}. The read clears the count. The count rises by one for each completed write (valid and ready both high) and saturates at 2^CNT_W−1.
- R8: `irq_o` is high exactly when the count is nonzero. It changes in the cycle after the count changes.
- R9: The following return the queue to its initial state: a write to address 0 or 1, a write to address 5 with bit 0 (soft) or bit 1 (global) set, and a read of address 6. The initial state has index, count, full, overflow and host read index at zero, with buffered and in-flight descriptors discarded. `mw_valid` is low in the next cycle.
- R10: Once raised, `mw_valid` stays high with stable address and data until `mw_ready` is seen, unless R9 applies.
- R11: Register reads return data on `reg_rdata` one cycle after `reg_rd`. Address 0 returns the base, 2 the host read index, 3 the mask, and 6 the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe |
| evt_cls | input | CLS_W | Event class, selects a mask bit |
| evt_desc | input | DESC_W | Descriptor word for the event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | AW | Memory write byte address |
| mw_data | output | DESC_W | Memory write data |
| irq_o | output | 1 | Level interrupt, high while count is nonzero |

## Verification
The bench builds the block with an 8-entry FIFO and a 4-bit count, keeping the default ring length limit. The small FIFO lets a dozen events overflow the buffer. The narrow count saturates after fifteen writes. The default length limit still allows the clamp at 32768 to be read back. Ring lengths of 4 and 64 exercise index wrap and the full stall within a few dozen cycles.

// File: rtl/irq_dq_pkg.sv
package irq_dq_pkg;

  // register addresses
  localparam logic [2:0] RA_BASE   = 3'd0;
  localparam logic [2:0] RA_LEN    = 3'd1;
  localparam logic [2:0] RA_HRD    = 3'd2;
  localparam logic [2:0] RA_MASK   = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;
  localparam logic [2:0] RA_CTRL   = 3'd5;
  localparam logic [2:0] RA_RELOAD = 3'd6;

  // status word fields
  localparam int ST_FULL = 15;
  localparam int ST_CNT  = 16;
  localparam int ST_OVF  = 31;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_FETCH = 2'd1,
    DR_SEND  = 2'd2
  } drain_st_e;

endpackage

// File: rtl/irq_dq_fifo.sv
module irq_dq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  logic do_wr, do_rd;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/irq_dq_regs.sv
module irq_dq_regs
  import irq_dq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_MAX = 32768,
  parameter int IDX_W   = 15,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 15,
  parameter int NCLS    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             q_full,
  input  logic             wr_done,
  input  logic             ovf_set,
  output logic             init_req,
  output logic [AW-1:0]    q_base,
  output logic [LEN_W-1:0] q_len,
  output logic [IDX_W-1:0] host_rd,
  output logic [NCLS-1:0]  mask,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_base;
  logic             ovf_q;
  logic             stat_rd;
  logic [LEN_W-1:0] len_in;
  logic [31:0]      status, rd_mux;

  assign init_req = (reg_wr && (reg_addr == RA_BASE || reg_addr == RA_LEN ||
                                (reg_addr == RA_CTRL && |reg_wdata[1:0]))) ||
                    (reg_rd && reg_addr == RA_RELOAD);
  assign stat_rd  = reg_rd && (reg_addr == RA_STAT);

  always_comb begin
    if (reg_wdata < 32'd2)                 len_in = LEN_W'(2);
    else if (reg_wdata > 32'(LEN_MAX))     len_in = LEN_W'(LEN_MAX);
    else                                   len_in = reg_wdata[LEN_W-1:0];
  end

  always_comb begin
    cnt_base = stat_rd ? '0 : cnt_q;
    cnt_nxt  = (wr_done && cnt_base != CNT_MAX) ? cnt_base + CNT_W'(1) : cnt_base;
  end

  always_comb begin
    status               = '0;
    status[IDX_W-1:0]    = wr_idx;
    status[ST_FULL]      = q_full;
    status[ST_CNT+:CNT_W] = cnt_q;
    status[ST_OVF]       = ovf_q;
  end

  always_comb begin
    case (reg_addr)
      RA_BASE:   rd_mux = 32'(q_base);
      RA_LEN:    rd_mux = 32'(q_len);
      RA_HRD:    rd_mux = 32'(host_rd);
      RA_MASK:   rd_mux = 32'(mask);
      RA_STAT:   rd_mux = status;
      RA_RELOAD: rd_mux = 32'(q_len);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_base    <= '0;
      q_len     <= LEN_W'(2);
      host_rd   <= '0;
      mask      <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      irq_o     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_BASE: q_base  <= {reg_wdata[AW-1:2], 2'b00};
          RA_LEN:  q_len   <= len_in;
          RA_HRD:  host_rd <= reg_wdata[IDX_W-1:0];
          RA_MASK: mask    <= reg_wdata[NCLS-1:0];
          default: ;
        endcase
      end
      if (init_req) begin
        host_rd <= '0;
        cnt_q   <= '0;
        ovf_q   <= 1'b0;
        irq_o   <= 1'b0;
      end else begin
        cnt_q <= cnt_nxt;
        irq_o <= (cnt_nxt != '0);
        if (ovf_set) ovf_q <= 1'b1;
      end
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_dq_drain.sv
module irq_dq_drain
  import irq_dq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 15,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_rdata,
  output logic             fifo_rd,
  input  logic [AW-1:0]    q_base,
  input  logic [LEN_W-1:0] q_len,
  input  logic [IDX_W-1:0] host_rd,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [AW-1:0]    mw_addr,
  output logic [DW-1:0]    mw_data,
  output logic [IDX_W-1:0] wr_idx,
  output logic             q_full,
  output logic             wr_done
);
  drain_st_e        st;
  logic [LEN_W-1:0] inc;
  logic [IDX_W-1:0] nxt_idx;

  assign inc     = {1'b0, wr_idx} + LEN_W'(1);
  assign nxt_idx = (inc >= q_len) ? '0 : inc[IDX_W-1:0];
  assign q_full  = (nxt_idx == host_rd);
  assign fifo_rd = (st == DR_IDLE) && !fifo_empty && !q_full && !init;
  assign wr_done = mw_valid && mw_ready;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      st       <= DR_IDLE;
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
      wr_idx   <= '0;
    end else begin
      case (st)
        DR_IDLE: if (fifo_rd) st <= DR_FETCH;
        DR_FETCH: begin
          mw_valid <= 1'b1;
          mw_data  <= fifo_rdata;
          mw_addr  <= q_base + AW'({wr_idx, 2'b00});
          st       <= DR_SEND;
        end
        DR_SEND: if (mw_ready) begin
          mw_valid <= 1'b0;
          wr_idx   <= nxt_idx;
          st       <= DR_IDLE;
        end
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_dq_mgr.sv
module irq_dq_mgr #(
  parameter int DESC_W     = 32,
  parameter int FIFO_DEPTH = 128,
  parameter int LEN_MAX    = 32768,
  parameter int CLS_W      = 3,
  parameter int CNT_W      = 15,
  parameter int AW         = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [CLS_W-1:0]  evt_cls,
  input  logic [DESC_W-1:0] evt_desc,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [AW-1:0]     mw_addr,
  output logic [DESC_W-1:0] mw_data,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(LEN_MAX);
  localparam int LEN_W = IDX_W + 1;
  localparam int NCLS  = 1 << CLS_W;

  logic              init_req;
  logic [AW-1:0]     q_base;
  logic [LEN_W-1:0]  q_len;
  logic [IDX_W-1:0]  host_rd, wr_idx;
  logic [NCLS-1:0]   mask;
  logic              q_full, wr_done;
  logic              fifo_full, fifo_empty, fifo_rd;
  logic [DESC_W-1:0] fifo_rdata;
  logic              accept, push, ovf_set;

  assign accept  = evt_valid && !mask[evt_cls];
  assign push    = accept && !fifo_full && !init_req;
  assign ovf_set = accept && fifo_full;

  irq_dq_regs #(
    .AW(AW), .LEN_MAX(LEN_MAX), .IDX_W(IDX_W), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .NCLS(NCLS)
  ) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_idx(wr_idx), .q_full(q_full), .wr_done(wr_done), .ovf_set(ovf_set),
    .init_req(init_req), .q_base(q_base), .q_len(q_len),
    .host_rd(host_rd), .mask(mask), .irq_o(irq_o)
  );

  irq_dq_fifo #(.DW(DESC_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .clr(rst || init_req),
    .wr_en(push), .wr_data(evt_desc),
    .rd_en(fifo_rd), .rd_data(fifo_rdata),
    .empty(fifo_empty), .full(fifo_full)
  );

  irq_dq_drain #(.AW(AW), .DW(DESC_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) drain_i (
    .clk(clk), .rst(rst), .init(init_req),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
    .q_base(q_base), .q_len(q_len), .host_rd(host_rd),
    .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data),
    .wr_idx(wr_idx), .q_full(q_full), .wr_done(wr_done)
  );
endmodule

// File: rtl/irq_dq_mgr_chk.sv
module irq_dq_mgr_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          init_req,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [DW-1:0] mw_data,
  input logic          irq_o
);
  // R3: byte addresses are word aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> mw_addr[1:0] == 2'b00);

  // R10: request held until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready && !init_req) |=>
      (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R9: re-initialisation drops the request and the interrupt
  a_r9_init_clear: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (!mw_valid && !irq_o));

  // R8: interrupt rises only after a completed write
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(mw_valid && mw_ready));

  // R7: status read with no concurrent write leaves the count at zero
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd4 && !(mw_valid && mw_ready) && !init_req) |=> !irq_o);
endmodule

bind irq_dq_mgr irq_dq_mgr_chk #(.AW(AW), .DW(DESC_W)) chk_i (
  .clk(clk), .rst(rst), .init_req(init_req),
  .reg_rd(reg_rd), .reg_addr(reg_addr),
  .mw_valid(mw_valid), .mw_ready(mw_ready),
  .mw_addr(mw_addr), .mw_data(mw_data), .irq_o(irq_o)
);

// File: tb/irq_dq_mgr_tb_top.sv
`timescale 1ns/1ps
module irq_dq_mgr_tb_top;
  localparam int DEPTH   = 8;
  localparam int CNTW    = 4;
  localparam int CMAX    = (1 << CNTW) - 1;
  localparam int LMAX    = 32768;
  localparam real TCLK   = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_cls = '0;
  logic [31:0] evt_desc = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mw_valid, mw_ready;
  logic [31:0] mw_addr, mw_data;
  logic        irq_o;

  always #(TCLK/2) clk = ~clk;

  irq_dq_mgr #(.FIFO_DEPTH(DEPTH), .CNT_W(CNTW), .LEN_MAX(LMAX)) dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_cls(evt_cls),
    .evt_desc(evt_desc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ready pattern
  int rdy_mode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: mw_ready = 1'b1;
      1: mw_ready = 1'b0;
      default: mw_ready = (cyc % 3) != 0;
    endcase
  end

  // ---------------- reference model ----------------
  logic [31:0] m_base;
  int          m_len, m_hrd, m_mask, m_widx, m_cnt, m_phase;
  bit          m_ovf;
  logic [31:0] m_q[$];
  logic [31:0] m_cur;
  bit          rd_pend;
  logic [31:0] rd_exp;
  string       rd_tag;
  bit          exp_full;

  function automatic int ring_next(int idx, int len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  function automatic int clamp_len(logic [31:0] v);
    if (v < 2) return 2;
    if (v > LMAX) return LMAX;
    return int'(v);
  endfunction

  always @(posedge clk) begin : model
    int  nxt, old_sz;
    bit  full, hs, init, srd;
    logic [31:0] st;
    if (rst) begin
      m_base = '0; m_len = 2; m_hrd = 0; m_mask = 0; m_widx = 0;
      m_cnt = 0; m_phase = 0; m_ovf = 0; m_q.delete(); m_cur = '0;
      rd_pend = 0;
    end else begin
      nxt    = ring_next(m_widx, m_len);
      full   = (nxt == m_hrd);
      hs     = (m_phase == 2) && mw_ready;
      old_sz = m_q.size();
      init   = (reg_wr && (reg_addr == 0 || reg_addr == 1 ||
                          (reg_addr == 5 && reg_wdata[1:0] != 0))) ||
               (reg_rd && reg_addr == 6);
      srd    = reg_rd && reg_addr == 4;
      rd_pend = reg_rd;
      if (reg_rd) begin
        st = {m_ovf, 15'(m_cnt), full, 15'(m_widx)};
        case (reg_addr)
          0: begin rd_exp = m_base;        rd_tag = "R11"; end
          1: begin rd_exp = 32'(m_len);    rd_tag = "R4";  end
          2: begin rd_exp = 32'(m_hrd);    rd_tag = "R11"; end
          3: begin rd_exp = 32'(m_mask);   rd_tag = "R11"; end
          4: begin rd_exp = st;            rd_tag = "R7";  end
          6: begin rd_exp = 32'(m_len);    rd_tag = "R9";  end
          default: begin rd_exp = '0;      rd_tag = "R11"; end
        endcase
      end
      if (reg_wr) begin
        case (reg_addr)
          0: m_base = {reg_wdata[31:2], 2'b00};
          1: m_len  = clamp_len(reg_wdata);
          2: m_hrd  = int'(reg_wdata[14:0]);
          3: m_mask = int'(reg_wdata[7:0]);
          default: ;
        endcase
      end
      if (init) begin
        m_widx = 0; m_cnt = 0; m_ovf = 0; m_hrd = 0; m_phase = 0;
        m_q.delete();
      end else begin
        case (m_phase)
          0: if (old_sz > 0 && !full) begin m_cur = m_q.pop_front(); m_phase = 1; end
          1: m_phase = 2;
          default: if (hs) begin m_widx = nxt; m_phase = 0; end
        endcase
        if (evt_valid && ((m_mask >> evt_cls) & 1) == 0) begin
          if (old_sz < DEPTH) m_q.push_back(evt_desc);
          else m_ovf = 1;
        end
        if (srd) m_cnt = 0;
        if (hs && m_cnt < CMAX) m_cnt++;
      end
      exp_full = (ring_next(m_widx, m_len) == m_hrd);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(exp_full ? "R5" : "R2", "mw_valid", 32'(mw_valid), 32'(m_phase == 2));
      if (m_phase == 2) begin
        check("R3", "mw_addr", mw_addr, m_base + 32'(m_widx) * 4);
        check("R10", "mw_data", mw_data, m_cur);
      end
      check("R8", "irq_o", 32'(irq_o), 32'(m_cnt != 0));
      if (rd_pend) check(rd_tag, "reg_rdata", reg_rdata, rd_exp);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic evt(input logic [2:0] c, input logic [31:0] d);
    evt_valid = 1'b1; evt_cls = c; evt_desc = d;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit done = 0;
  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "mw_valid", 32'(mw_valid), 0);
    check("R1", "irq_o", 32'(irq_o), 0);
    rd(4, d); check("R1", "status", d, 0);

    // R2/R3: mask class 2, ring of 4, stalled ready
    rdy_mode = 2;
    wr(0, 32'h1000_0003);
    wr(1, 4);
    wr(3, 32'h04);
    evt(0, 32'hA0); evt(1, 32'hA1); evt(2, 32'hA2);
    evt(3, 32'hA3); evt(2, 32'hA4); evt(5, 32'hA5);
    idle(30);
    rd(4, d); check("R5", "status full bit", 32'(d[15]), 1);
    rd(0, d); check("R11", "base", d, 32'h1000_0000);

    // R5 resume and R3 wrap
    wr(2, 2);
    idle(10);
    evt(0, 32'hB0); evt(0, 32'hB1); evt(1, 32'hB2);
    idle(20);

    // R6: overflow with ring stuck full
    rdy_mode = 0;
    for (int i = 0; i < 12; i++) evt(1, 32'hC0 + 32'(i));
    idle(10);
    rd(4, d); check("R6", "status overflow bit", 32'(d[31]), 1);
    rd(4, d); check("R7", "count after clear", 32'(d[30:16]), 0);
    check("R8", "irq after clear", 32'(irq_o), 0);

    // R9: global init
    wr(5, 32'h2);
    rd(4, d); check("R9", "status after init", d, 0);

    // R7: saturating count
    rdy_mode = 2;
    wr(1, 64);
    for (int i = 0; i < 20; i++) begin evt(4, 32'hD0 + 32'(i)); idle(4); end
    idle(40);
    rd(4, d); check("R7", "saturated count", 32'(d[30:16]), CMAX);

    // R10 hold, then R9 reload read while in flight
    rdy_mode = 1;
    evt(0, 32'hE0);
    idle(8);
    check("R10", "held request", 32'(mw_valid), 1);
    rd(6, d);
    check("R9", "request dropped", 32'(mw_valid), 0);
    rd(4, d); check("R9", "status after reload", d, 0);
    rdy_mode = 0;

    // R4: length clamp
    wr(1, 1);     rd(1, d); check("R4", "len low clamp", d, 2);
    wr(1, 40000); rd(1, d); check("R4", "len high clamp", d, LMAX);
    wr(1, 8);     rd(1, d); check("R4", "len in range", d, 8);

    // R9 negative: control write without init bits keeps state
    evt(6, 32'hF0); evt(7, 32'hF1);
    idle(12);
    wr(5, 32'h4);
    rd(4, d); check("R9", "count kept", 32'(d[30:16]), 2);

    // R2: everything masked
    wr(3, 32'hFF);
    evt(0, 32'h11); evt(7, 32'h22);
    idle(10);
    rd(4, d); check("R2", "masked count", 32'(d[30:16]), 0);
    rd(3, d);

    idle(5);
    done = 1;
    summary();
    $finish;
  end
endmodule